// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block holds the in-flight stores of an out-of-order core in a circular queue and answers load lookups against them. Each slot keeps a store's sequence number, its effective address, its size code and data, and three status flags: data written, committed, and written back to memory. Stores are allocated in program order at the tail. The data-write port fills in address, size and data later. A commit marks every store up to a given sequence number. A writeback-complete marks one slot as done, and a finished slot leaves from the head. A squash cuts off every store younger than a given sequence number.

A load presents its sequence number, address and size on the lookup port. The queue considers only the stores older than the load and gets one of four answers: forward data from a store that covers the load, stall and replay on a partial overlap, go to memory, or refuse an uncacheable load that is not yet the oldest one at commit. The answer appears one cycle after the lookup. DEPTH must be a power of two. Sequence numbers are 16 bits, addresses 32 bits and data 64 bits.

Top module: `stq_fwd`

## Requirements
- R1: A lookup considers only stores that are older than the load. Store a is older than load b when the 16-bit difference a−b, read as signed, is negative, so the comparison stays correct across the point where the numbers wrap.
- R2: Among the older stores, the youngest one that decides the outcome sets the result. A store whose data has not yet been written is skipped.
- R3: A store covers a load when the load's first byte is at or above the store's first byte and the load's last byte is at or below the store's last byte. A store that covers the load gives result kind 1 (forward). Result kinds are 0 memory, 1 forward, 2 stall, 3 refuse.
- R4: Forwarded data is the store data shifted right by 8×(load address AND (store bytes−1)) bits, then masked to the load size. Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R5: A store whose bytes intersect the load's bytes without covering them gives kind 2 (stall) unless it has already been written back. A store that has been written back is skipped.
- R6: When no older store decides the outcome, the result is kind 0 (memory). In every result that is not a forward, the data is zero.
- R7: The result of a lookup is valid exactly one cycle after the lookup is presented.
- R8: `full` is high when the occupied slot count reaches DEPTH−1. While `full` is high, an allocation is ignored and the tail index does not move.
- R9: An uncacheable load that is not flagged as the oldest load at commit gets kind 3 (refuse).
- R10: A commit marks every held store whose sequence number is not younger than the commit number. Committed stores are skipped by lookups. A lookup presented in the same cycle as a commit sees the state from before that commit.
- R11: A squash with number N removes every store younger than N. The tail rolls back so that the next allocation reuses the first removed slot.
- R12: Writeback-complete marks a slot as done. The head slot leaves the queue once it is done, which frees capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_seq | input | 16 | Sequence number of the new store |
| alloc_idx | output | IW | Slot index that the next allocation takes |
| full | output | 1 | Occupied count has reached DEPTH−1 |
| wr_valid | input | 1 | Write address, size and data into a slot |
| wr_idx | input | IW | Slot to write |
| wr_addr | input | 32 | Store effective address |
| wr_size | input | 2 | Store size code |
| wr_data | input | 64 | Store data |
| commit_valid | input | 1 | Commit stores up to commit_seq |
| commit_seq | input | 16 | Youngest sequence number to commit |
| wb_valid | input | 1 | A slot's memory write has finished |
| wb_idx | input | IW | Slot that finished |
| squash_valid | input | 1 | Remove stores younger than squash_seq |
| squash_seq | input | 16 | Squash boundary |
| ld_valid | input | 1 | Load lookup request |
| ld_seq | input | 16 | Load sequence number |
| ld_addr | input | 32 | Load address |
| ld_size | input | 2 | Load size code |
| ld_uncache | input | 1 | Load is uncacheable |
| ld_oldest | input | 1 | Load is the oldest load and is at commit |
| res_valid | output | 1 | Lookup result valid |
| res_kind | output | 2 | Result kind |
| res_data | output | 64 | Forwarded data |

## Verification
A lookup and a commit can fall in the same cycle. The lookup must then be judged against the queue as it stood before the commit edge. The bench provokes this by driving a commit of every held store together with a lookup that a written store fully covers. It expects a forward in that result and a memory answer from an identical lookup one cycle later. Squash and allocate can also meet, and in that case the squash wins. The bench checks the squash on its own through the rolled-back tail index.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int SEQ_W  = 16;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 64;
  localparam int AW1    = ADDR_W + 1;

  typedef logic [SEQ_W-1:0]  seq_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam logic [1:0] RES_MEM    = 2'd0;
  localparam logic [1:0] RES_FWD    = 2'd1;
  localparam logic [1:0] RES_STALL  = 2'd2;
  localparam logic [1:0] RES_REFUSE = 2'd3;

  // a is older than b (wrap-safe)
  function automatic logic seq_older(input seq_t a, input seq_t b);
    seq_t d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic logic [3:0] nbytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

  function automatic logic covers(input addr_t la, input logic [1:0] lc,
                                  input addr_t sa, input logic [1:0] sc);
    logic [AW1-1:0] le, se;
    le = {1'b0, la} + AW1'(nbytes(lc));
    se = {1'b0, sa} + AW1'(nbytes(sc));
    return (la >= sa) && (le <= se);
  endfunction

  function automatic logic overlaps(input addr_t la, input logic [1:0] lc,
                                    input addr_t sa, input logic [1:0] sc);
    logic [AW1-1:0] le, se;
    le = {1'b0, la} + AW1'(nbytes(lc));
    se = {1'b0, sa} + AW1'(nbytes(sc));
    return ({1'b0, la} < se) && (le > {1'b0, sa});
  endfunction

  function automatic data_t size_mask(input logic [1:0] code);
    case (code)
      2'd0:    return data_t'(64'hFF);
      2'd1:    return data_t'(64'hFFFF);
      2'd2:    return data_t'(64'hFFFF_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic data_t fwd_value(input data_t d, input addr_t la,
                                      input logic [1:0] sc, input logic [1:0] lc);
    logic [2:0] off;
    logic [5:0] sh;
    off = la[2:0] & 3'(nbytes(sc) - 4'd1);
    sh  = {off, 3'b000};
    return (d >> sh) & size_mask(lc);
  endfunction
endpackage

// File: rtl/stq_match.sv
module stq_match import stq_pkg::*; (
  input  logic       vld,
  input  logic       written,
  input  logic       committed,
  input  logic       done,
  input  seq_t       s_seq,
  input  addr_t      s_addr,
  input  logic [1:0] s_size,
  input  seq_t       l_seq,
  input  addr_t      l_addr,
  input  logic [1:0] l_size,
  output logic       decide,
  output logic       full_hit
);
  logic eligible, cov, ovl;

  assign eligible = vld && written && !committed && seq_older(s_seq, l_seq);
  assign cov      = covers(l_addr, l_size, s_addr, s_size);
  assign ovl      = overlaps(l_addr, l_size, s_addr, s_size);
  assign full_hit = cov;
  assign decide   = eligible && (cov || (ovl && !done));
endmodule

// File: rtl/stq_pick.sv
module stq_pick #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] decide,
  input  logic [DEPTH-1:0] full_hit,
  input  logic [IW-1:0]    head,
  output logic             found,
  output logic             sel_full,
  output logic [IW-1:0]    sel
);
  // scan from oldest to youngest; the last decider (youngest) wins
  always_comb begin
    found    = 1'b0;
    sel_full = 1'b0;
    sel      = '0;
    for (int p = 0; p < DEPTH; p++) begin
      logic [IW-1:0] idx;
      idx = head + IW'(p);
      if (decide[idx]) begin
        found    = 1'b1;
        sel      = idx;
        sel_full = full_hit[idx];
      end
    end
  end
endmodule

// File: rtl/stq_fwd.sv
module stq_fwd import stq_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SEQ_W-1:0]  alloc_seq,
  output logic [IW-1:0]     alloc_idx,
  output logic              full,
  input  logic              wr_valid,
  input  logic [IW-1:0]     wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_valid,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic              wb_valid,
  input  logic [IW-1:0]     wb_idx,
  input  logic              squash_valid,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              ld_valid,
  input  logic [SEQ_W-1:0]  ld_seq,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_uncache,
  input  logic              ld_oldest,
  output logic              res_valid,
  output logic [1:0]        res_kind,
  output logic [DATA_W-1:0] res_data
);
  logic [IW:0] head_q, tail_q, cnt, surv;
  seq_t       e_seq  [DEPTH];
  addr_t      e_addr [DEPTH];
  logic [1:0] e_sz   [DEPTH];
  data_t      e_data [DEPTH];
  logic [DEPTH-1:0] e_wr, e_cm, e_cp, e_vld;
  logic [DEPTH-1:0] decide, full_hit;

  // named events
  logic do_alloc, do_retire, found, sel_full;
  logic [IW-1:0] sel;
  logic [1:0] nxt_kind;
  data_t nxt_data;

  assign cnt       = tail_q - head_q;
  assign full      = cnt >= (IW+1)'(DEPTH - 1);
  assign alloc_idx = tail_q[IW-1:0];
  assign do_alloc  = alloc_valid && !full && !squash_valid;
  assign do_retire = (cnt != '0) && e_cp[head_q[IW-1:0]];

  always_comb begin
    surv = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [IW-1:0] pos;
      pos = IW'(i) - head_q[IW-1:0];
      e_vld[i] = {1'b0, pos} < cnt;
      if (e_vld[i] && !seq_older(squash_seq, e_seq[i]))
        surv = surv + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      e_wr   <= '0;
      e_cm   <= '0;
      e_cp   <= '0;
    end else begin
      if (do_retire) head_q <= head_q + 1'b1;
      if (squash_valid)  tail_q <= head_q + surv;
      else if (do_alloc) tail_q <= tail_q + 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        if (do_alloc && (IW'(i) == alloc_idx)) begin
          e_wr[i] <= 1'b0;
          e_cm[i] <= 1'b0;
          e_cp[i] <= 1'b0;
        end else begin
          if (wr_valid && (IW'(i) == wr_idx)) e_wr[i] <= 1'b1;
          if (commit_valid && e_vld[i] && !seq_older(commit_seq, e_seq[i]))
            e_cm[i] <= 1'b1;
          if (wb_valid && (IW'(i) == wb_idx)) e_cp[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (do_alloc && (IW'(i) == alloc_idx)) e_seq[i] <= alloc_seq;
      if (wr_valid && (IW'(i) == wr_idx)) begin
        e_addr[i] <= wr_addr;
        e_sz[i]   <= wr_size;
        e_data[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    stq_match u_match (
      .vld(e_vld[g]), .written(e_wr[g]), .committed(e_cm[g]), .done(e_cp[g]),
      .s_seq(e_seq[g]), .s_addr(e_addr[g]), .s_size(e_sz[g]),
      .l_seq(ld_seq), .l_addr(ld_addr), .l_size(ld_size),
      .decide(decide[g]), .full_hit(full_hit[g])
    );
  end

  stq_pick #(.DEPTH(DEPTH)) u_pick (
    .decide(decide), .full_hit(full_hit), .head(head_q[IW-1:0]),
    .found(found), .sel_full(sel_full), .sel(sel)
  );

  always_comb begin
    nxt_kind = RES_MEM;
    nxt_data = '0;
    if (ld_uncache && !ld_oldest) begin
      nxt_kind = RES_REFUSE;
    end else if (found) begin
      if (sel_full) begin
        nxt_kind = RES_FWD;
        nxt_data = fwd_value(e_data[sel], ld_addr, e_sz[sel], ld_size);
      end else begin
        nxt_kind = RES_STALL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_kind  <= RES_MEM;
      res_data  <= '0;
    end else begin
      res_valid <= ld_valid;
      res_kind  <= ld_valid ? nxt_kind : RES_MEM;
      res_data  <= ld_valid ? nxt_data : '0;
    end
  end
endmodule

// File: rtl/stq_fwd_chk.sv
module stq_fwd_chk #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic [IW:0] cnt,
  input logic        full,
  input logic        squash_valid,
  input logic        ld_valid,
  input logic        ld_uncache,
  input logic        ld_oldest,
  input logic        res_valid,
  input logic [1:0]  res_kind,
  input logic [63:0] res_data
);
  assert_result_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);
  assert_no_spurious_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);
  assert_refuse_uncached_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_uncache && !ld_oldest) |=> (res_kind == 2'd3));
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (IW+1)'(DEPTH - 1));
  assert_no_alloc_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt <= $past(cnt)));
  assert_squash_shrinks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> (cnt <= $past(cnt)));
  assert_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind != 2'd1) |-> (res_data == 64'd0));
endmodule

bind stq_fwd stq_fwd_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .full(full), .squash_valid(squash_valid),
  .ld_valid(ld_valid), .ld_uncache(ld_uncache), .ld_oldest(ld_oldest),
  .res_valid(res_valid), .res_kind(res_kind), .res_data(res_data)
);

// File: tb/stq_fwd_tb_top.sv
module stq_fwd_tb_top;
  localparam int DEPTH = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0; logic [15:0] alloc_seq = 0; logic [IW-1:0] alloc_idx; logic full;
  logic wr_valid = 0; logic [IW-1:0] wr_idx = 0; logic [31:0] wr_addr = 0;
  logic [1:0] wr_size = 0; logic [63:0] wr_data = 0;
  logic commit_valid = 0; logic [15:0] commit_seq = 0;
  logic wb_valid = 0; logic [IW-1:0] wb_idx = 0;
  logic squash_valid = 0; logic [15:0] squash_seq = 0;
  logic ld_valid = 0; logic [15:0] ld_seq = 0; logic [31:0] ld_addr = 0;
  logic [1:0] ld_size = 0; logic ld_uncache = 0; logic ld_oldest = 0;
  logic res_valid; logic [1:0] res_kind; logic [63:0] res_data;

  int checks = 0, fails = 0;
  bit finished = 0;

  typedef struct { logic [1:0] k; logic [63:0] d; string r; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  stq_fwd #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic alloc(input logic [15:0] s);
    alloc_valid = 1; alloc_seq = s; @(negedge clk); alloc_valid = 0;
  endtask

  task automatic wr(input logic [IW-1:0] i, input logic [31:0] a, input logic [1:0] z, input logic [63:0] d);
    wr_valid = 1; wr_idx = i; wr_addr = a; wr_size = z; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic set_ld(input logic [15:0] s, input logic [31:0] a, input logic [1:0] z,
                        input bit unc, input bit old, input logic [1:0] ek,
                        input logic [63:0] ed, input string r);
    exp_t e;
    e.k = ek; e.d = ed; e.r = r;
    sb.push_back(e);
    ld_valid = 1; ld_seq = s; ld_addr = a; ld_size = z; ld_uncache = unc; ld_oldest = old;
  endtask

  task automatic lookup(input logic [15:0] s, input logic [31:0] a, input logic [1:0] z,
                        input bit unc, input bit old, input logic [1:0] ek,
                        input logic [63:0] ed, input string r);
    set_ld(s, a, z, unc, old, ek, ed, r);
    @(negedge clk); ld_valid = 0;
  endtask

  // monitor: pops expectations as results appear
  initial begin
    forever begin
      @(posedge clk); #2;
      if (res_valid) begin
        if (sb.size() == 0) begin
          chk(0, "R7 unexpected result", 64'(res_kind), 64'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(res_kind == e.k, {e.r, " kind"}, 64'(res_kind), 64'(e.k));
          chk(res_data == e.d, {e.r, " data"}, res_data, e.d);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    chk(0, "watchdog", 0, 0);
    if (!finished) begin
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [IW-1:0] saved;
    repeat (2) @(negedge clk);
    chk(full == 0 && res_valid == 0 && alloc_idx == 0, "R8 reset state", {62'd0, full, res_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    alloc(16'd10); alloc(16'd20); alloc(16'd30);
    wr(0, 32'h100, 2'd3, 64'h8877665544332211);
    wr(1, 32'h104, 2'd2, 64'h00000000AABBCCDD);
    lookup(16'd40, 32'h104, 2'd2, 0, 0, 2'd1, 64'hAABBCCDD, "R3 full cover");
    lookup(16'd40, 32'h106, 2'd1, 0, 0, 2'd1, 64'hAABB, "R4 shifted forward");
    lookup(16'd15, 32'h104, 2'd2, 0, 0, 2'd1, 64'h88776655, "R1 older only");
    lookup(16'd40, 32'h102, 2'd2, 0, 0, 2'd2, 64'd0, "R5 partial stall");
    lookup(16'd40, 32'h200, 2'd3, 0, 0, 2'd0, 64'd0, "R6 no match");
    lookup(16'd5,  32'h100, 2'd3, 0, 0, 2'd0, 64'd0, "R1 no older store");
    lookup(16'd40, 32'h104, 2'd2, 1, 0, 2'd3, 64'd0, "R9 refuse");
    lookup(16'd40, 32'h104, 2'd2, 1, 1, 2'd1, 64'hAABBCCDD, "R9 oldest uncached");
    wr(2, 32'h101, 2'd0, 64'h5A);
    lookup(16'd40, 32'h101, 2'd0, 0, 0, 2'd1, 64'h5A, "R2 youngest decides");
    // commit and lookup in the same cycle
    commit_valid = 1; commit_seq = 16'd30;
    set_ld(16'd40, 32'h101, 2'd0, 0, 0, 2'd1, 64'h5A, "R10 same-cycle commit");
    @(negedge clk); commit_valid = 0; ld_valid = 0;
    lookup(16'd40, 32'h101, 2'd0, 0, 0, 2'd0, 64'd0, "R10 committed skipped");
    // squash
    alloc(16'd50); alloc(16'd60);
    wr(4, 32'h300, 2'd2, 64'h11112222);
    lookup(16'd70, 32'h300, 2'd2, 0, 0, 2'd1, 64'h11112222, "R11 before squash");
    squash_valid = 1; squash_seq = 16'd50; @(negedge clk); squash_valid = 0;
    chk(alloc_idx == 4, "R11 tail rollback", 64'(alloc_idx), 64'd4);
    lookup(16'd70, 32'h300, 2'd2, 0, 0, 2'd0, 64'd0, "R11 squashed gone");
    alloc(16'd55);
    chk(alloc_idx == 5, "R11 reuse slot", 64'(alloc_idx), 64'd5);
    // writeback frees space
    for (int i = 0; i < 3; i++) begin
      wb_valid = 1; wb_idx = IW'(i); @(negedge clk); wb_valid = 0;
    end
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) alloc(16'd56 + 16'(i));
    chk(full == 0, "R12 space freed", 64'(full), 64'd0);
    alloc(16'd61);
    chk(full == 1, "R8 full at DEPTH-1", 64'(full), 64'd1);
    saved = alloc_idx;
    alloc(16'd62);
    chk(alloc_idx == saved && full == 1, "R8 alloc ignored when full", 64'(alloc_idx), 64'(saved));
    // wrap of sequence numbers
    rst_n = 0; @(negedge clk);
    chk(full == 0 && res_valid == 0 && alloc_idx == 0, "R8 reset again", 64'(alloc_idx), 0);
    rst_n = 1; @(negedge clk);
    alloc(16'hFFF0);
    wr(0, 32'h400, 2'd2, 64'hCAFEF00D);
    lookup(16'h0005, 32'h400, 2'd2, 0, 0, 2'd1, 64'hCAFEF00D, "R1 wrap older");
    lookup(16'hFFE0, 32'h400, 2'd2, 0, 0, 2'd0, 64'd0, "R1 wrap younger");
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R7 all results seen", 64'(sb.size()), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule